// File: doc/BRIEF.md
# Embedded SRAM Self-Test Engine with Spare-Row Allocation

This block tests one single-port synchronous SRAM. A pulse on `start` launches a six-element march of solid zero and solid one backgrounds. The march issues one memory operation on every functional clock. Read data is compared one cycle after each read is issued. Every mismatch is reported on a fail strobe that carries the word address.

Failing rows (the upper address bits) are allocated into a small table of spare rows. At the end the memory is placed in one of three bins: clean, fixable with spare rows, or beyond repair. For a fixable memory the engine presents the row addresses that the redundancy logic must substitute. If more distinct rows fail than there are spares, the run stops early.

Several engines can be wired to one shared `start` and run side by side, each on its own memory.

Top module: `sram_bist`

## Requirements
- R1: The engine issues exactly one SRAM operation per clock with no idle cycles. For a run that does not overflow the spares, `done` is high in the cycle after the 10N+2-th rising edge that follows the edge sampling `start` (N = 2^ADDR_W words).
- R2: The operation order is: write 0 to all words ascending. Then, per word ascending: read expecting 0, write 1. Then, per word ascending: read expecting 1, write 0. Then, per word descending (word N-1 first): read expecting 0, write 1. Then, per word descending: read expecting 1, write 0. Finally, read expecting 0 over all words ascending. Here "0" means all data bits clear and "1" means all bits set.
- R3: Each read whose data differs from the expected value produces a one-cycle `fail_valid` pulse with `fail_addr` equal to that word address. As a consequence, a single bit stuck at 1 yields exactly 3 pulses and a single bit stuck at 0 yields exactly 2 pulses.
- R4: With no failing read, `bin` = 0 (clean) and `repair_vld` = 0 when `done` rises.
- R5: With 1 to SPARES distinct failing rows, `bin` = 1 (fixable). Spare entries are filled from index 0 upward in the order in which each row first fails. For each filled entry i, bit i of `repair_vld` is set and `repair_rows[i*ROW_W +: ROW_W]` holds the row, where row = address bits [ADDR_W-1:COL_W].
- R6: A row that fails more than once, whether at the same word or at different words of that row, occupies one spare entry only.
- R7: When a distinct failing row arrives with all spares in use, `bin` = 2 (beyond repair). The march is abandoned, and `done` rises two clock edges after the `fail_valid` pulse carrying that row.
- R8: `done` is high for exactly one cycle. `bin`, `repair_vld` and `repair_rows` then hold their values until the next `start`, which clears the old result and begins a new run.
- R9: Engines sharing one `start` each test their own memory and report their own bin and repair rows.
- R10: After reset, `busy`, `done`, `mem_we`, `fail_valid`, `bin` and `repair_vld` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a test run (accepted while idle) |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| mem_addr | output | ADDR_W | SRAM word address |
| mem_we | output | 1 | SRAM write enable (read when low during a run) |
| mem_wdata | output | DATA_W | SRAM write data |
| mem_rdata | input | DATA_W | SRAM read data, valid one cycle after the read address |
| fail_valid | output | 1 | A compared word mismatched |
| fail_addr | output | ADDR_W | Address of the mismatching word |
| bin | output | 2 | 0 clean, 1 fixable, 2 beyond repair |
| repair_vld | output | SPARES | Valid bit per spare-row entry |
| repair_rows | output | SPARES*ROW_W | Row address per spare entry, entry 0 in the low bits |

## Verification
The assertions assume a memory with exactly one cycle of read latency. They also assume that `start` is raised only while `busy` is low, so a run is never restarted midway. The bench models the SRAM as a registered array and injects faults by forcing bits on its read path, which keeps the latency fixed. It raises `start` for a single cycle only after the previous run has signalled `done`. Two engines share that pulse. Across the runs, every address receives a stuck-at-1 bit on one engine and a stuck-at-0 bit on the other.

// File: rtl/bist_pkg.sv
package bist_pkg;

  typedef enum logic [2:0] {
    M_W0      = 3'd0,
    M_R0W1_UP = 3'd1,
    M_R1W0_UP = 3'd2,
    M_R0W1_DN = 3'd3,
    M_R1W0_DN = 3'd4,
    M_R0      = 3'd5
  } march_e;

  typedef enum logic [1:0] {
    BIN_GOOD   = 2'd0,
    BIN_REPAIR = 2'd1,
    BIN_DEAD   = 2'd2
  } bin_e;

  typedef enum logic [1:0] {
    C_IDLE = 2'd0,
    C_RUN  = 2'd1,
    C_FIN  = 2'd2
  } ctrl_e;

endpackage

// File: rtl/bist_march_seq.sv
module bist_march_seq
  import bist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  output logic              seq_end,
  output logic [ADDR_W-1:0] addr,
  output logic              we,
  output logic [DATA_W-1:0] wdata,
  output logic              cmp_valid,
  output logic [ADDR_W-1:0] cmp_addr,
  output logic [DATA_W-1:0] cmp_exp
);

  march_e            elem_q;
  logic [ADDR_W-1:0] idx_q;
  logic              ph_q;
  logic              run_q;
  logic              rw_elem, desc, rd_one, wr_one, is_rd, elem_last;

  always_comb begin
    rw_elem   = elem_q inside {M_R0W1_UP, M_R1W0_UP, M_R0W1_DN, M_R1W0_DN};
    desc      = elem_q inside {M_R0W1_DN, M_R1W0_DN};
    rd_one    = elem_q inside {M_R1W0_UP, M_R1W0_DN};
    wr_one    = elem_q inside {M_R0W1_UP, M_R0W1_DN};
    addr      = desc ? ~idx_q : idx_q;
    we        = run_q && (elem_q == M_W0 || (rw_elem && ph_q));
    wdata     = wr_one ? '1 : '0;
    is_rd     = run_q && !we;
    elem_last = (&idx_q) && (!rw_elem || ph_q);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q     <= 1'b0;
      elem_q    <= M_W0;
      idx_q     <= '0;
      ph_q      <= 1'b0;
      seq_end   <= 1'b0;
      cmp_valid <= 1'b0;
      cmp_addr  <= '0;
      cmp_exp   <= '0;
    end else begin
      seq_end   <= 1'b0;
      cmp_valid <= is_rd;
      cmp_addr  <= addr;
      cmp_exp   <= rd_one ? '1 : '0;
      if (go) begin
        run_q  <= 1'b1;
        elem_q <= M_W0;
        idx_q  <= '0;
        ph_q   <= 1'b0;
      end else if (run_q) begin
        if (abort) begin
          run_q <= 1'b0;
        end else if (elem_last) begin
          idx_q <= '0;
          ph_q  <= 1'b0;
          if (elem_q == M_R0) begin
            run_q   <= 1'b0;
            seq_end <= 1'b1;
          end else begin
            elem_q <= march_e'(elem_q + 3'd1);
          end
        end else if (rw_elem && !ph_q) begin
          ph_q <= 1'b1;
        end else begin
          ph_q  <= 1'b0;
          idx_q <= idx_q + 1'b1;
        end
      end
    end
  end

  // R2
  rd_then_wr_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && !we && rw_elem && !abort) |=> (we && $stable(addr)));

endmodule

// File: rtl/bist_fail_table.sv
module bist_fail_table #(
  parameter int ROW_W  = 4,
  parameter int SPARES = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic                    fail_in,
  input  logic [ROW_W-1:0]        fail_row,
  output logic [SPARES-1:0]       vld,
  output logic [SPARES*ROW_W-1:0] rows,
  output logic                    ovf
);

  logic              hit, found;
  logic [SPARES-1:0] pick;

  always_comb begin
    hit   = 1'b0;
    found = 1'b0;
    pick  = '0;
    for (int i = 0; i < SPARES; i++) begin
      if (vld[i] && rows[i*ROW_W +: ROW_W] == fail_row) hit = 1'b1;
      if (!vld[i] && !found) begin
        found   = 1'b1;
        pick[i] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      vld  <= '0;
      rows <= '0;
      ovf  <= 1'b0;
    end else if (fail_in && !hit) begin
      if (!found) ovf <= 1'b1;
      for (int i = 0; i < SPARES; i++) begin
        if (pick[i]) begin
          vld[i]                  <= 1'b1;
          rows[i*ROW_W +: ROW_W]  <= fail_row;
        end
      end
    end
  end

  logic dup;
  always_comb begin
    dup = 1'b0;
    for (int i = 0; i < SPARES; i++)
      for (int j = i + 1; j < SPARES; j++)
        if (vld[i] && vld[j] && rows[i*ROW_W +: ROW_W] == rows[j*ROW_W +: ROW_W]) dup = 1'b1;
  end

  // R6
  no_dup_row_chk: assert property (@(posedge clk) disable iff (rst) !dup);

  // R7
  full_before_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf) |-> (&vld));

endmodule

// File: rtl/sram_bist.sv
module sram_bist
  import bist_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int COL_W  = 2,
  parameter int SPARES = 2,
  localparam int ROW_W = ADDR_W - COL_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  output logic                    busy,
  output logic                    done,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic                    mem_we,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic [DATA_W-1:0]       mem_rdata,
  output logic                    fail_valid,
  output logic [ADDR_W-1:0]       fail_addr,
  output logic [1:0]              bin,
  output logic [SPARES-1:0]       repair_vld,
  output logic [SPARES*ROW_W-1:0] repair_rows
);

  ctrl_e                   state_q;
  logic                    go, abort, seq_end, mismatch, ovf;
  logic                    cmp_valid;
  logic [ADDR_W-1:0]       cmp_addr;
  logic [DATA_W-1:0]       cmp_exp;
  logic [SPARES-1:0]       tbl_vld;
  logic [SPARES*ROW_W-1:0] tbl_rows;

  assign go       = start && state_q == C_IDLE;
  assign abort    = state_q == C_RUN && ovf;
  assign mismatch = busy && cmp_valid && (mem_rdata != cmp_exp);

  bist_march_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
    .clk(clk), .rst(rst), .go(go), .abort(abort), .seq_end(seq_end),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata),
    .cmp_valid(cmp_valid), .cmp_addr(cmp_addr), .cmp_exp(cmp_exp)
  );

  bist_fail_table #(.ROW_W(ROW_W), .SPARES(SPARES)) u_tbl (
    .clk(clk), .rst(rst), .clr(go), .fail_in(mismatch),
    .fail_row(cmp_addr[ADDR_W-1:COL_W]),
    .vld(tbl_vld), .rows(tbl_rows), .ovf(ovf)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= C_IDLE;
      busy        <= 1'b0;
      done        <= 1'b0;
      fail_valid  <= 1'b0;
      fail_addr   <= '0;
      bin         <= BIN_GOOD;
      repair_vld  <= '0;
      repair_rows <= '0;
    end else begin
      done       <= 1'b0;
      fail_valid <= mismatch;
      fail_addr  <= cmp_addr;
      unique case (state_q)
        C_IDLE: if (go) begin
          state_q     <= C_RUN;
          busy        <= 1'b1;
          bin         <= BIN_GOOD;
          repair_vld  <= '0;
          repair_rows <= '0;
        end
        C_RUN: if (ovf || seq_end) state_q <= C_FIN;
        C_FIN: begin
          state_q     <= C_IDLE;
          busy        <= 1'b0;
          done        <= 1'b1;
          bin         <= ovf ? BIN_DEAD : (|tbl_vld ? BIN_REPAIR : BIN_GOOD);
          repair_vld  <= tbl_vld;
          repair_rows <= tbl_rows;
        end
        default: state_q <= C_IDLE;
      endcase
    end
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst) done |=> !done);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !$past(busy) && !$past(start)) |-> ($stable(bin) && $stable(repair_vld)));

  // R4
  good_no_repair_chk: assert property (@(posedge clk) disable iff (rst)
    (done && bin == BIN_GOOD) |-> (repair_vld == '0));

  // R1
  we_only_busy_chk: assert property (@(posedge clk) disable iff (rst) mem_we |-> busy);

endmodule

// File: tb/sram_bist_bench.sv
module sram_bist_bench;
  localparam int CLK_P = 10;
  localparam int AW = 6;
  localparam int DW = 8;
  localparam int N  = 1 << AW;
  localparam int RW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  logic          busy_a, done_a, we_a, fv_a, busy_b, done_b, we_b, fv_b;
  logic [AW-1:0] addr_a, fa_a, addr_b, fa_b;
  logic [DW-1:0] wd_a, rd_a, wd_b, rd_b;
  logic [1:0]    bin_a, bin_b, rv_a, rv_b;
  logic [2*RW-1:0] rows_a, rows_b;

  sram_bist u_sram_bist (
    .clk(clk), .rst(rst), .start(start), .busy(busy_a), .done(done_a),
    .mem_addr(addr_a), .mem_we(we_a), .mem_wdata(wd_a), .mem_rdata(rd_a),
    .fail_valid(fv_a), .fail_addr(fa_a), .bin(bin_a),
    .repair_vld(rv_a), .repair_rows(rows_a));

  sram_bist u_sram_bist_b (
    .clk(clk), .rst(rst), .start(start), .busy(busy_b), .done(done_b),
    .mem_addr(addr_b), .mem_we(we_b), .mem_wdata(wd_b), .mem_rdata(rd_b),
    .fail_valid(fv_b), .fail_addr(fa_b), .bin(bin_b),
    .repair_vld(rv_b), .repair_rows(rows_b));

  logic [DW-1:0] mem_a [N];
  logic [DW-1:0] mem_b [N];
  logic [DW-1:0] s0_a [N];
  logic [DW-1:0] s1_a [N];
  logic [DW-1:0] s0_b [N];
  logic [DW-1:0] s1_b [N];

  always @(posedge clk) begin
    if (we_a) mem_a[addr_a] <= wd_a;
    rd_a <= (mem_a[addr_a] & ~s0_a[addr_a]) | s1_a[addr_a];
    if (we_b) mem_b[addr_b] <= wd_b;
    rd_b <= (mem_b[addr_b] & ~s0_b[addr_b]) | s1_b[addr_b];
  end

  int n_chk = 0, n_err = 0;
  int nf_a, nf_b, bad_a, bad_b, exp_fa_a, exp_fa_b;

  always @(negedge clk) begin
    if (fv_a) begin
      nf_a++;
      if (exp_fa_a >= 0 && int'(fa_a) != exp_fa_a) bad_a++;
    end
    if (fv_b) begin
      nf_b++;
      if (exp_fa_b >= 0 && int'(fa_b) != exp_fa_b) bad_b++;
    end
  end

  task automatic chk(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_faults();
    for (int i = 0; i < N; i++) begin
      s0_a[i] = '0; s1_a[i] = '0; s0_b[i] = '0; s1_b[i] = '0;
    end
    exp_fa_a = -1;
    exp_fa_b = -1;
  endtask

  // expected operation k of the march (R2)
  task automatic exp_op(input int k, output logic we, output int a, output logic [DW-1:0] d);
    if (k < N) begin
      we = 1'b1; a = k; d = '0;
    end else if (k < 9*N) begin
      int j, el, r, i;
      j = k - N; el = j / (2*N) + 1; r = j % (2*N); i = r / 2;
      a  = (el >= 3) ? N - 1 - i : i;
      we = (r % 2) == 1;
      d  = (el == 1 || el == 3) ? '1 : '0;
    end else begin
      we = 1'b0; a = k - 9*N; d = '0;
    end
  endtask

  int cyc_a, cyc_b, seq_bad;

  task automatic run(input bit seqchk);
    int cyc;
    logic e_we; int e_a; logic [DW-1:0] e_d;
    nf_a = 0; nf_b = 0; bad_a = 0; bad_b = 0; seq_bad = 0;
    cyc_a = -1; cyc_b = -1;
    @(negedge clk) start = 1'b1;
    @(posedge clk);
    @(negedge clk) start = 1'b0;
    cyc = 0;
    forever begin
      if (seqchk && cyc < 10*N) begin
        exp_op(cyc, e_we, e_a, e_d);
        if (we_a != e_we || int'(addr_a) != e_a || (e_we && wd_a != e_d)) seq_bad++;
      end
      if (done_a && cyc_a < 0) cyc_a = cyc;
      if (done_b && cyc_b < 0) cyc_b = cyc;
      if (cyc_a >= 0 && cyc_b >= 0) break;
      if (cyc > 20*N) begin
        chk("watchdog", cyc, 0);
        break;
      end
      @(posedge clk);
      cyc++;
      @(negedge clk);
    end
    @(negedge clk);
  endtask

  initial begin
    clear_faults();
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk("R10 busy", busy_a, 0);
    chk("R10 done", done_a, 0);
    chk("R10 mem_we", we_a, 0);
    chk("R10 fail_valid", fv_a, 0);
    chk("R10 bin", bin_a, 0);
    chk("R10 repair_vld", rv_a, 0);

    // clean memories
    run(1'b1);
    chk("R2 op sequence mismatches", seq_bad, 0);
    chk("R1 cycles to done", cyc_a, 10*N + 2);
    chk("R4 bin clean", bin_a, 0);
    chk("R4 repair_vld clean", rv_a, 0);
    chk("R3 no fail pulses", nf_a, 0);
    chk("R9 second engine cycles", cyc_b, 10*N + 2);
    chk("R9 second engine bin", bin_b, 0);
    // R8 done pulse and hold
    chk("R8 done one cycle", done_a, 0);
    repeat (5) @(negedge clk);
    chk("R8 bin held", bin_a, 0);
    chk("R8 done stays low", done_a, 0);

    // sweep: stuck-at-1 on engine a, stuck-at-0 on engine b
    for (int a = 0; a < N; a++) begin
      clear_faults();
      s1_a[a][a % DW] = 1'b1;
      s0_b[N-1-a][(a + 3) % DW] = 1'b1;
      exp_fa_a = a;
      exp_fa_b = N - 1 - a;
      run(1'b0);
      chk("R3 stuck1 fail count", nf_a, 3);
      chk("R3 stuck1 fail addr", bad_a, 0);
      chk("R5 single row bin", bin_a, 1);
      chk("R5 single row vld", rv_a, 1);
      chk("R5 single row value", rows_a[RW-1:0], a >> 2);
      chk("R1 repairable cycles", cyc_a, 10*N + 2);
      chk("R3 stuck0 fail count", nf_b, 2);
      chk("R3 stuck0 fail addr", bad_b, 0);
      chk("R9 engine b bin", bin_b, 1);
      chk("R9 engine b row", rows_b[RW-1:0], (N - 1 - a) >> 2);
    end

    // R6 two faults in one row
    clear_faults();
    s1_a[8][0] = 1'b1;
    s0_a[10][3] = 1'b1;
    run(1'b0);
    chk("R6 fail pulses", nf_a, 5);
    chk("R6 bin", bin_a, 1);
    chk("R6 one entry", rv_a, 1);
    chk("R6 row", rows_a[RW-1:0], 2);

    // R5 detection order differs from address order
    clear_faults();
    s1_a[40][5] = 1'b1;
    s0_a[12][1] = 1'b1;
    run(1'b0);
    chk("R5 two rows bin", bin_a, 1);
    chk("R5 two rows vld", rv_a, 3);
    chk("R5 entry0 row", rows_a[RW-1:0], 10);
    chk("R5 entry1 row", rows_a[2*RW-1:RW], 3);

    // R7 three distinct rows
    clear_faults();
    s1_a[4][2] = 1'b1;
    s1_a[20][6] = 1'b1;
    s1_a[50][7] = 1'b1;
    run(1'b0);
    chk("R7 bin unrepairable", bin_a, 2);
    chk("R7 early done cycle", cyc_a, N + 2*50 + 4);
    chk("R9 clean engine unaffected", bin_b, 0);

    // R8 next start clears previous verdict
    clear_faults();
    run(1'b0);
    chk("R8 rerun bin", bin_a, 0);
    chk("R8 rerun vld", rv_a, 0);

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

endmodule